// File: doc/BRIEF.md
# Send handshake controller

This block coordinates a send between a processing element and a transmit path. It is a clocked version of a burst-mode controller. Five handshake inputs are watched: send request, transmit request, queue read, address-build done and packet acknowledge. From them the block drives three acknowledge and strobe outputs. The controller walks through eleven states. It leaves a state only once every input change an exit arc expects has arrived. The outputs change on that same arc.

Each input first passes through a synchronizer chain of `SYNC_STAGES` flops. The state and the outputs sit in registers. Two paths run through the state graph. In the first, the controller serves a read, a second read, and then either a further read pair that loops back or a packet acknowledge. In the second, the acknowledge exit leads into a transmit request / acknowledge loop, which returns to idle when send request drops. Queue read and packet acknowledge must never be high together. If the synchronized inputs show both high, a sticky error flag is raised.

Top module: `send_hs_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, all three outputs and `proto_err` are low and the controller is idle (state 0).
- R2: In state 0, once `send_req`, `tx_req` and `q_read` are all high, the controller enters state 1 with outputs {tx_ack,pe_ack,addr_build} = 001.
- R3: On `addr_done` high, state 1 moves to state 2 (011) and state 4 moves to state 5 (111). On `q_read` low, state 2 moves to state 3 (100) and state 5 moves to state 6 (000).
- R4: State 3 has two exits. With `tx_req` low, `q_read` high and `addr_done` low it enters state 4 (101). With `tx_req` low, `pkt_ack` high and `addr_done` low it enters state 8 (110).
- R5: State 6 has two exits. With `tx_req` high, `q_read` high and `addr_done` low it returns to state 1 (001). With `tx_req` high, `pkt_ack` high and `addr_done` low it enters state 7 (110).
- R6: State 7 enters state 9 (000) only when `pkt_ack` and `tx_req` are both low. State 8 enters state 9 (000) when `pkt_ack` is low.
- R7: State 9 moves to state 10 (100) on `tx_req` high. State 10 returns to state 9 (000) on `tx_req` low. State 9 returns to state 0 (000) on `send_req` low. When both exits of state 9 are enabled, the `tx_req` exit wins.
- R8: If the inputs complete only part of a burst, or match no arc of the current state, the state and outputs stay unchanged.
- R9: When the synchronized `q_read` and `pkt_ack` are both high, `proto_err` is set and stays set until reset. No transition happens while that conflict lasts.
- R10: An input change shows on the outputs at the third rising clock edge after it is applied (two synchronizer stages plus the output register, default `SYNC_STAGES` = 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| send_req | input | 1 | Send request from the processing element |
| tx_req | input | 1 | Transmit request |
| q_read | input | 1 | Input queue read |
| addr_done | input | 1 | Address build complete |
| pkt_ack | input | 1 | Packet acknowledge |
| tx_ack | output | 1 | Transmit acknowledge |
| pe_ack | output | 1 | Processing-element acknowledge |
| addr_build | output | 1 | Address build strobe |
| proto_err | output | 1 | Sticky error: queue read and packet acknowledge seen high together |

## Verification
The assertions assume that all bits of an input burst reach the synchronizers in the same cycle. Without that, a burst could be split into partial steps. The stimulus meets this by changing every input of a burst at one falling edge, and then holding the inputs steady for several cycles before the next burst. The assertions also assume that queue read and packet acknowledge are never high together. Only the dedicated error scenario breaks this, and there the assertions check only the hold and sticky-flag behaviour.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_BUILD1 = 4'd1,
    ST_ACK1   = 4'd2,
    ST_SENT1  = 4'd3,
    ST_BUILD2 = 4'd4,
    ST_ACK2   = 4'd5,
    ST_SENT2  = 4'd6,
    ST_PKT6   = 4'd7,
    ST_PKT3   = 4'd8,
    ST_WAIT   = 4'd9,
    ST_TXLOOP = 4'd10
  } hs_state_t;

  typedef struct packed {
    logic req;
    logic treq;
    logic rd;
    logic done;
    logic ack;
  } hs_in_t;

  typedef struct packed {
    logic tack;
    logic peack;
    logic adb;
  } hs_out_t;

  localparam int HS_IN_W = $bits(hs_in_t);

  // Output levels held in each state, {tack, peack, adb}.
  function automatic hs_out_t state_outputs(hs_state_t s);
    hs_out_t o;
    case (s)
      ST_BUILD1: o = 3'b001;
      ST_ACK1:   o = 3'b011;
      ST_SENT1:  o = 3'b100;
      ST_BUILD2: o = 3'b101;
      ST_ACK2:   o = 3'b111;
      ST_PKT6:   o = 3'b110;
      ST_PKT3:   o = 3'b110;
      ST_TXLOOP: o = 3'b100;
      default:   o = 3'b000;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else if (STAGES == 1) chain <= d[b];
      else chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/hs_arc_decode.sv
module hs_arc_decode
  import hs_pkg::*;
(
  input  hs_state_t cur,
  input  hs_in_t    in,
  output logic      hit,
  output hs_state_t nxt
);

  always_comb begin
    hit = 1'b0;
    nxt = cur;
    case (cur)
      ST_IDLE:
        if (in.req && in.treq && in.rd) begin hit = 1'b1; nxt = ST_BUILD1; end
      ST_BUILD1:
        if (in.done) begin hit = 1'b1; nxt = ST_ACK1; end
      ST_ACK1:
        if (!in.rd) begin hit = 1'b1; nxt = ST_SENT1; end
      ST_SENT1:
        if (!in.treq && !in.done && in.rd) begin hit = 1'b1; nxt = ST_BUILD2; end
        else if (!in.treq && !in.done && in.ack) begin hit = 1'b1; nxt = ST_PKT3; end
      ST_BUILD2:
        if (in.done) begin hit = 1'b1; nxt = ST_ACK2; end
      ST_ACK2:
        if (!in.rd) begin hit = 1'b1; nxt = ST_SENT2; end
      ST_SENT2:
        if (in.treq && !in.done && in.rd) begin hit = 1'b1; nxt = ST_BUILD1; end
        else if (in.treq && !in.done && in.ack) begin hit = 1'b1; nxt = ST_PKT6; end
      ST_PKT6:
        if (!in.ack && !in.treq) begin hit = 1'b1; nxt = ST_WAIT; end
      ST_PKT3:
        if (!in.ack) begin hit = 1'b1; nxt = ST_WAIT; end
      ST_WAIT:
        if (in.treq) begin hit = 1'b1; nxt = ST_TXLOOP; end
        else if (!in.req) begin hit = 1'b1; nxt = ST_IDLE; end
      ST_TXLOOP:
        if (!in.treq) begin hit = 1'b1; nxt = ST_WAIT; end
      default: begin hit = 1'b1; nxt = ST_IDLE; end
    endcase
  end

endmodule

// File: rtl/hs_state_reg.sv
module hs_state_reg
  import hs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      hit,
  input  hs_state_t nxt,
  input  logic      conflict,
  output hs_state_t cur,
  output hs_out_t   outs,
  output logic      err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= ST_IDLE;
      outs <= '0;
      err  <= 1'b0;
    end else begin
      if (conflict) err <= 1'b1;
      if (hit && !conflict) begin
        cur  <= nxt;
        outs <= state_outputs(nxt);
      end
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (cur == ST_IDLE && outs == 3'b000 && !err));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  p_hold_conflict_r9: assert property (@(posedge clk) disable iff (rst)
    conflict |=> ($stable(cur) && $stable(outs) && err));

  p_hold_nomatch_r8: assert property (@(posedge clk) disable iff (rst)
    !hit |=> ($stable(cur) && $stable(outs)));

endmodule

// File: rtl/send_hs_ctrl.sv
module send_hs_ctrl
  import hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic send_req,
  input  logic tx_req,
  input  logic q_read,
  input  logic addr_done,
  input  logic pkt_ack,
  output logic tx_ack,
  output logic pe_ack,
  output logic addr_build,
  output logic proto_err
);

  logic [HS_IN_W-1:0] raw_in;
  logic [HS_IN_W-1:0] syn_in;
  hs_in_t    s_in;
  hs_state_t cur, nxt;
  hs_out_t   outs;
  logic      hit;
  logic      conflict;

  assign raw_in = {send_req, tx_req, q_read, addr_done, pkt_ack};

  hs_sync #(.WIDTH(HS_IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn_in)
  );

  assign s_in     = hs_in_t'(syn_in);
  assign conflict = s_in.rd && s_in.ack;

  hs_arc_decode u_dec (
    .cur(cur), .in(s_in), .hit(hit), .nxt(nxt)
  );

  hs_state_reg u_reg (
    .clk(clk), .rst(rst), .hit(hit), .nxt(nxt), .conflict(conflict),
    .cur(cur), .outs(outs), .err(err_w)
  );

  logic err_w;
  assign tx_ack     = outs.tack;
  assign pe_ack     = outs.peack;
  assign addr_build = outs.adb;
  assign proto_err  = err_w;

  // Build strobe only rises on an arc that needs queue read high (R2, R4, R5).
  p_adb_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_build) |-> $past(s_in.rd));

  // Acknowledge rises only after build done or packet acknowledge (R3).
  p_peack_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(pe_ack) |-> $past(s_in.done || s_in.ack));

  // Leaving state 7 needs both transmit request and packet acknowledge low (R6).
  p_pkt6_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (cur == ST_PKT6 && (s_in.treq || s_in.ack)) |=> (cur == ST_PKT6));

endmodule

// File: tb/tb_send_hs_ctrl.sv
`timescale 1ns/1ps
module tb_send_hs_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic send_req = 0, tx_req = 0, q_read = 0, addr_done = 0, pkt_ack = 0;
  logic tx_ack, pe_ack, addr_build, proto_err;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  send_hs_ctrl dut (
    .clk(clk), .rst(rst), .send_req(send_req), .tx_req(tx_req),
    .q_read(q_read), .addr_done(addr_done), .pkt_ack(pkt_ack),
    .tx_ack(tx_ack), .pe_ack(pe_ack), .addr_build(addr_build),
    .proto_err(proto_err)
  );

  task automatic check_out(input logic [2:0] exp, input logic exp_err, input string req);
    n_vec++;
    if ({tx_ack, pe_ack, addr_build} !== exp || proto_err !== exp_err) begin
      n_bad++;
      $display("FAIL %s: out=%b err=%b expected out=%b err=%b",
               req, {tx_ack, pe_ack, addr_build}, proto_err, exp, exp_err);
    end
  endtask

  // v = {send_req, tx_req, q_read, addr_done, pkt_ack}
  task automatic drive(input logic [4:0] v);
    @(negedge clk);
    {send_req, tx_req, q_read, addr_done, pkt_ack} = v;
  endtask

  task automatic step(input logic [4:0] v, input logic [2:0] exp,
                      input logic exp_err, input string req);
    drive(v);
    repeat (4) @(posedge clk);
    #1;
    check_out(exp, exp_err, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    {send_req, tx_req, q_read, addr_done, pkt_ack} = 5'b0;
    repeat (4) @(posedge clk);
    #1;
    check_out(3'b000, 1'b0, "R1 reset");
    @(negedge clk);
    rst = 1'b0;
  endtask

  // R10 latency and R2 entry
  task automatic t_latency();
    do_reset();
    drive(5'b11100);
    repeat (2) @(posedge clk);
    #1;
    check_out(3'b000, 1'b0, "R10 unchanged after two edges");
    @(posedge clk);
    #1;
    check_out(3'b001, 1'b0, "R10/R2 changed at third edge");
  endtask

  // Double read path 0-1-2-3-4-5-6-1, then acknowledge exit via 8 into 9/10 loop
  task automatic t_double_read();
    do_reset();
    step(5'b11000, 3'b000, 1'b0, "R8 partial burst in state 0");
    step(5'b11100, 3'b001, 1'b0, "R2 enter state 1");
    step(5'b11110, 3'b011, 1'b0, "R3 state 1 to 2");
    step(5'b11010, 3'b100, 1'b0, "R3 state 2 to 3");
    step(5'b10100, 3'b101, 1'b0, "R4 state 3 to 4");
    step(5'b10110, 3'b111, 1'b0, "R3 state 4 to 5");
    step(5'b10010, 3'b000, 1'b0, "R3 state 5 to 6");
    step(5'b11100, 3'b001, 1'b0, "R5 state 6 back to 1");
    step(5'b11110, 3'b011, 1'b0, "R3 second state 1 to 2");
    step(5'b11010, 3'b100, 1'b0, "R3 second state 2 to 3");
    step(5'b10001, 3'b110, 1'b0, "R4 state 3 to 8");
    step(5'b10000, 3'b000, 1'b0, "R6 state 8 to 9");
    step(5'b11000, 3'b100, 1'b0, "R7 state 9 to 10");
    step(5'b10000, 3'b000, 1'b0, "R7 state 10 to 9");
    step(5'b00000, 3'b000, 1'b0, "R7 state 9 to 0");
    step(5'b11100, 3'b001, 1'b0, "R7 idle reached, re-entry to 1");
  endtask

  // Path through state 7, then priority of the transmit request exit in state 9
  task automatic t_pkt_exit();
    do_reset();
    step(5'b11100, 3'b001, 1'b0, "R2 enter state 1");
    step(5'b11110, 3'b011, 1'b0, "R3 state 1 to 2");
    step(5'b11010, 3'b100, 1'b0, "R3 state 2 to 3");
    step(5'b10100, 3'b101, 1'b0, "R4 state 3 to 4");
    step(5'b10110, 3'b111, 1'b0, "R3 state 4 to 5");
    step(5'b10010, 3'b000, 1'b0, "R3 state 5 to 6");
    step(5'b11001, 3'b110, 1'b0, "R5 state 6 to 7");
    step(5'b11000, 3'b110, 1'b0, "R6 state 7 holds with tx_req high");
    step(5'b10000, 3'b000, 1'b0, "R6 state 7 to 9");
    step(5'b01000, 3'b100, 1'b0, "R7 tx_req exit wins over send_req low");
    step(5'b00000, 3'b000, 1'b0, "R7 state 10 to 9 then 0");
    step(5'b11100, 3'b001, 1'b0, "R7 back in idle, enters 1");
  endtask

  // Protocol conflict in state 6
  task automatic t_conflict();
    do_reset();
    step(5'b11100, 3'b001, 1'b0, "R2 enter state 1");
    step(5'b11110, 3'b011, 1'b0, "R3 state 1 to 2");
    step(5'b11010, 3'b100, 1'b0, "R3 state 2 to 3");
    step(5'b10100, 3'b101, 1'b0, "R4 state 3 to 4");
    step(5'b10110, 3'b111, 1'b0, "R3 state 4 to 5");
    step(5'b10010, 3'b000, 1'b0, "R3 state 5 to 6");
    step(5'b11101, 3'b000, 1'b1, "R9 conflict sets flag and holds state");
    step(5'b11100, 3'b001, 1'b1, "R9 flag sticky after conflict ends");
    do_reset();
  endtask

  initial begin
    fork
      begin
        t_latency();
        t_double_read();
        t_pkt_exit();
        t_conflict();
      end
      begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule